// File: doc/BRIEF.md
# Memory-Mapped ATA Task-File Bridge

This block lets a big-endian host reach an ATA device's task-file registers through a 4 KB memory window. The window is divided into 16-byte slots. The slot number selects the target: a task-file register, the shared control/status location, or the data port. Byte accesses go to the 8-bit registers. Halfword and word accesses reach the data port only, and they cross the bridge byte-reversed, so a big-endian host sees the device's little-endian data stream in its native order.

The host side is a single-cycle address/data bus. It has a size code and separate read and write strobes. Device-side strobes follow the host strobes in the same cycle. Read data is captured at the clock edge that ends the read cycle, and the host sees it one cycle after the read strobe. The bridge also drives a reset line toward the attached device bus, which follows the block's own reset.

Top module: `ata_mmio_bridge`

## Requirements
- R1: The slot index is host address bits [11:4]. Address bits above bit 11 and below bit 4 have no effect, so the window repeats every 4096 bytes.
- R2: A byte access (size code 2'b00) at slot 1 to 7 pulses `dev_tf_wr` or `dev_tf_rd`, with `dev_tf_reg` equal to the slot number. A write puts `host_wdata[7:0]` on `dev_wdata[7:0]`. A read returns {24'h0, `dev_tf_rdata`}.
- R3: A byte write at slot 8 or slot 22 pulses `dev_ctl_wr`, with `host_wdata[7:0]` on `dev_wdata[7:0]`.
- R4: A byte read at slot 8 or slot 22 pulses `dev_stat_rd` and returns {24'h0, `dev_stat_rdata`}.
- R5: A byte read at any other slot returns 32'h0000_00FF. A byte write there pulses no device strobe.
- R6: A halfword access (size code 2'b01) at slot 0 pulses `dev_data_wr` or `dev_data_rd`, with `dev_data_wide` low. Write data is {16'h0, w[7:0], w[15:8]}. A read returns {16'h0, r[7:0], r[15:8]}, where r is `dev_data_rdata`.
- R7: A word access (size code 2'b10) at slot 0 pulses the data strobe with `dev_data_wide` high. The four bytes are reversed in both directions.
- R8: A halfword read at a nonzero slot returns 32'h0000_FFFF. A word read there, or a read with size code 2'b11 anywhere, returns 32'hFFFF_FFFF. A halfword, word or size-2'b11 write at any of these places pulses no device strobe.
- R9: `host_rdata` takes its new value at the clock edge that ends the read cycle. It holds that value until the next read, and it is zero after reset.
- R10: At most one device strobe is high in any cycle. If `host_wr` and `host_rd` are both high, only the write is performed.
- R11: `dev_reset` is high while `rst_n` is low, and it falls at the first clock edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 32 | Host byte address |
| host_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data, right-aligned |
| host_rdata | output | 32 | Host read data, valid one cycle after the read |
| dev_tf_wr | output | 1 | Task-file register write strobe |
| dev_tf_rd | output | 1 | Task-file register read strobe |
| dev_tf_reg | output | 3 | Task-file register number |
| dev_ctl_wr | output | 1 | Device-control register write strobe |
| dev_stat_rd | output | 1 | Status register read strobe |
| dev_data_wr | output | 1 | Data port write strobe |
| dev_data_rd | output | 1 | Data port read strobe |
| dev_data_wide | output | 1 | Data port transfer is 32-bit (else 16-bit) |
| dev_wdata | output | 32 | Write data toward the device |
| dev_tf_rdata | input | 8 | Task-file register read value |
| dev_stat_rdata | input | 8 | Status register read value |
| dev_data_rdata | input | 32 | Data port read value, little-endian |
| dev_reset | output | 1 | Reset toward the attached device bus |

## Verification
The assertions check on every cycle that at most one device strobe fires and that each strobe appears only at the slots that own it. They also check that halfword write data is byte-reversed, that status and unmapped byte reads return the right value one cycle later, that read data holds between reads, and that the device reset is high during reset. Only the bench sweeps can show the whole decode map: every slot under every size and direction, with upper address bits varied. The bench scenarios also cover the word-swap ordering, the halfword and word fill values, and the write-over-read priority.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE    = 2'd0,
    TGT_TASK    = 2'd1,
    TGT_CTLSTAT = 2'd2,
    TGT_DATA    = 2'd3
  } acc_tgt_e;

endpackage

// File: rtl/ata_win_decode.sv
module ata_win_decode
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIN_BITS  = 12,
  parameter int SLOT_BITS = 4,
  parameter int TF_FIRST  = 1,
  parameter int TF_LAST   = 7,
  parameter int CS_SLOT_A = 8,
  parameter int CS_SLOT_B = 22,
  parameter int DATA_SLOT = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  output acc_tgt_e          tgt,
  output logic [2:0]        tf_reg
);
  localparam int IDX_W = WIN_BITS - SLOT_BITS;

  logic [IDX_W-1:0] slot;
  assign slot   = addr[WIN_BITS-1:SLOT_BITS];
  assign tf_reg = slot[2:0];

  always_comb begin
    tgt = TGT_NONE;
    case (size)
      SZ_BYTE: begin
        if (slot >= IDX_W'(TF_FIRST) && slot <= IDX_W'(TF_LAST))
          tgt = TGT_TASK;
        else if (slot == IDX_W'(CS_SLOT_A) || slot == IDX_W'(CS_SLOT_B))
          tgt = TGT_CTLSTAT;
      end
      SZ_HALF, SZ_WORD: begin
        if (slot == IDX_W'(DATA_SLOT))
          tgt = TGT_DATA;
      end
      default: tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/ata_lane_swap.sv
module ata_lane_swap #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*LANE_W +: LANE_W] = din[(LANES-1-g)*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ata_rd_stage.sv
module ata_rd_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (en) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign dout = hold_q;
endmodule

// File: rtl/ata_mmio_bridge.sv
module ata_mmio_bridge
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIN_BITS  = 12,
  parameter int SLOT_BITS = 4,
  parameter int CS_SLOT_A = 8,
  parameter int CS_SLOT_B = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              dev_tf_wr,
  output logic              dev_tf_rd,
  output logic [2:0]        dev_tf_reg,
  output logic              dev_ctl_wr,
  output logic              dev_stat_rd,
  output logic              dev_data_wr,
  output logic              dev_data_rd,
  output logic              dev_data_wide,
  output logic [31:0]       dev_wdata,
  input  logic [7:0]        dev_tf_rdata,
  input  logic [7:0]        dev_stat_rdata,
  input  logic [31:0]       dev_data_rdata,
  output logic              dev_reset
);
  localparam int IDX_W = WIN_BITS - SLOT_BITS;

  acc_size_e size_e;
  acc_tgt_e  tgt;
  logic      wr_go, rd_go;
  logic [15:0] wsw16, rsw16;
  logic [31:0] wsw32, rsw32;
  logic [31:0] rd_mux;
  logic        rst_q, rst_d;
  logic [IDX_W-1:0] slot_chk;

  assign size_e   = acc_size_e'(host_size);
  assign wr_go    = host_wr;
  assign rd_go    = host_rd & ~host_wr;
  assign slot_chk = host_addr[WIN_BITS-1:SLOT_BITS];

  ata_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SLOT_BITS(SLOT_BITS),
    .TF_FIRST(1), .TF_LAST(7),
    .CS_SLOT_A(CS_SLOT_A), .CS_SLOT_B(CS_SLOT_B), .DATA_SLOT(0)
  ) u_decode (
    .addr(host_addr), .size(size_e), .tgt(tgt), .tf_reg(dev_tf_reg)
  );

  ata_lane_swap #(.LANES(2)) u_wsw16 (.din(host_wdata[15:0]),     .dout(wsw16));
  ata_lane_swap #(.LANES(4)) u_wsw32 (.din(host_wdata),           .dout(wsw32));
  ata_lane_swap #(.LANES(2)) u_rsw16 (.din(dev_data_rdata[15:0]), .dout(rsw16));
  ata_lane_swap #(.LANES(4)) u_rsw32 (.din(dev_data_rdata),       .dout(rsw32));

  assign dev_tf_wr     = wr_go & (tgt == TGT_TASK);
  assign dev_tf_rd     = rd_go & (tgt == TGT_TASK);
  assign dev_ctl_wr    = wr_go & (tgt == TGT_CTLSTAT);
  assign dev_stat_rd   = rd_go & (tgt == TGT_CTLSTAT);
  assign dev_data_wr   = wr_go & (tgt == TGT_DATA);
  assign dev_data_rd   = rd_go & (tgt == TGT_DATA);
  assign dev_data_wide = (size_e == SZ_WORD);

  always_comb begin
    case (size_e)
      SZ_HALF: dev_wdata = {16'h0, wsw16};
      SZ_WORD: dev_wdata = wsw32;
      default: dev_wdata = {24'h0, host_wdata[7:0]};
    endcase
  end

  always_comb begin
    case (tgt)
      TGT_TASK:    rd_mux = {24'h0, dev_tf_rdata};
      TGT_CTLSTAT: rd_mux = {24'h0, dev_stat_rdata};
      TGT_DATA:    rd_mux = (size_e == SZ_WORD) ? rsw32 : {16'h0, rsw16};
      default: begin
        case (size_e)
          SZ_BYTE: rd_mux = 32'h0000_00FF;
          SZ_HALF: rd_mux = 32'h0000_FFFF;
          default: rd_mux = 32'hFFFF_FFFF;
        endcase
      end
    endcase
  end

  ata_rd_stage #(.DATA_W(32)) u_rd_stage (
    .clk(clk), .rst_n(rst_n), .en(rd_go), .din(rd_mux), .dout(host_rdata)
  );

  assign rst_d = 1'b0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b1;
    else        rst_q <= rst_d;
  end
  assign dev_reset = rst_q;

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_tf_wr, dev_tf_rd, dev_ctl_wr, dev_stat_rd, dev_data_wr, dev_data_rd})); // R10

  AST_TF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tf_wr || dev_tf_rd) |-> (host_size == 2'b00 && slot_chk >= IDX_W'(1)
      && slot_chk <= IDX_W'(7) && dev_tf_reg == slot_chk[2:0])); // R2

  AST_CS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ctl_wr || dev_stat_rd) |-> (host_size == 2'b00
      && (slot_chk == IDX_W'(CS_SLOT_A) || slot_chk == IDX_W'(CS_SLOT_B)))); // R3

  AST_DATA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_data_wr || dev_data_rd) |-> (slot_chk == '0 && host_size[1] != host_size[0])); // R7

  AST_HALF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_data_wr && !dev_data_wide) |->
      dev_wdata == {16'h0, host_wdata[7:0], host_wdata[15:8]}); // R6

  AST_STAT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    dev_stat_rd |=> host_rdata == {24'h0, $past(dev_stat_rdata)}); // R4

  AST_UNMAPPED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_size == 2'b00 && !dev_tf_rd && !dev_stat_rd)
      |=> host_rdata == 32'h0000_00FF); // R5

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && !host_wr) |=> $stable(host_rdata)); // R9

  always @(negedge clk) begin
    if (!rst_n) AST_DEV_RESET: assert (dev_reset); // R11
  end
endmodule

// File: tb/test_ata_mmio_bridge.sv
module test_ata_mmio_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] host_addr;
  logic [1:0]  host_size;
  logic        host_wr, host_rd;
  logic [31:0] host_wdata, host_rdata;
  logic        dev_tf_wr, dev_tf_rd, dev_ctl_wr, dev_stat_rd;
  logic        dev_data_wr, dev_data_rd, dev_data_wide, dev_reset;
  logic [2:0]  dev_tf_reg;
  logic [31:0] dev_wdata;
  logic [7:0]  dev_tf_rdata, dev_stat_rdata;
  logic [31:0] dev_data_rdata;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] last_rd;

  always #4 clk = ~clk;

  assign dev_tf_rdata = {5'b10100, dev_tf_reg};

  ata_mmio_bridge i_ata_mmio_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_size(host_size),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dev_tf_wr(dev_tf_wr), .dev_tf_rd(dev_tf_rd),
    .dev_tf_reg(dev_tf_reg), .dev_ctl_wr(dev_ctl_wr), .dev_stat_rd(dev_stat_rd),
    .dev_data_wr(dev_data_wr), .dev_data_rd(dev_data_rd),
    .dev_data_wide(dev_data_wide), .dev_wdata(dev_wdata),
    .dev_tf_rdata(dev_tf_rdata), .dev_stat_rdata(dev_stat_rdata),
    .dev_data_rdata(dev_data_rdata), .dev_reset(dev_reset)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input int idx, input int sz, input bit wr, input bit rd,
                        input logic [19:0] hi);
    logic [31:0] w, d, exp_rd, exp_wd;
    logic [5:0]  exp_s, act_s;
    int          k;
    bit          do_wr, do_rd;
    string       tag;
    w = {idx[7:0] ^ 8'hA5, idx[7:0] + 8'h13, 8'(sz) ^ 8'h6C, idx[7:0] ^ 8'h0F};
    d = {8'hC1 ^ idx[7:0], 8'h2D, idx[7:0] + 8'h77, 8'(sz) + 8'h90};
    do_wr = wr;
    do_rd = rd && !wr;
    k = 0;
    if (sz == 0 && idx >= 1 && idx <= 7) k = 1;
    else if (sz == 0 && (idx == 8 || idx == 22)) k = 2;
    else if ((sz == 1 || sz == 2) && idx == 0) k = 3;
    case (k)
      1: tag = "R2";
      2: tag = do_wr ? "R3" : "R4";
      3: tag = (sz == 1) ? "R6" : "R7";
      default: tag = (sz == 0) ? "R5" : "R8";
    endcase
    case (k)
      1: exp_rd = {24'h0, 5'b10100, idx[2:0]};
      2: exp_rd = {24'h0, idx[7:0] + 8'h40};
      3: exp_rd = (sz == 2) ? {d[7:0], d[15:8], d[23:16], d[31:24]}
                            : {16'h0, d[7:0], d[15:8]};
      default: exp_rd = (sz == 0) ? 32'h0000_00FF :
                        (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endcase
    exp_wd = (sz == 2) ? {w[7:0], w[15:8], w[23:16], w[31:24]} :
             (sz == 1) ? {16'h0, w[7:0], w[15:8]} : {24'h0, w[7:0]};
    exp_s = {do_wr && k == 1, do_rd && k == 1, do_wr && k == 2,
             do_rd && k == 2, do_wr && k == 3, do_rd && k == 3};
    @(negedge clk);
    host_addr      = {hi, idx[7:0], idx[3:0] ^ 4'h9};
    host_size      = 2'(sz);
    host_wr        = wr;
    host_rd        = rd;
    host_wdata     = w;
    dev_data_rdata = d;
    dev_stat_rdata = idx[7:0] + 8'h40;
    #1;
    act_s = {dev_tf_wr, dev_tf_rd, dev_ctl_wr, dev_stat_rd, dev_data_wr, dev_data_rd};
    chk(act_s == exp_s, tag, {26'h0, act_s}, {26'h0, exp_s});
    if (wr && rd) chk(!dev_tf_rd && !dev_stat_rd && !dev_data_rd, "R10",
                      {26'h0, act_s}, {26'h0, exp_s});
    if (k == 1) chk(dev_tf_reg == idx[2:0], "R2", {29'h0, dev_tf_reg}, 32'(idx[2:0]));
    if (k == 3) chk(dev_data_wide == (sz == 2), tag, {31'h0, dev_data_wide}, 32'(sz == 2));
    if (do_wr && k != 0) chk(dev_wdata == exp_wd, tag, dev_wdata, exp_wd);
    @(negedge clk);
    host_wr = 1'b0;
    host_rd = 1'b0;
    if (do_rd) begin
      chk(host_rdata == exp_rd, tag, host_rdata, exp_rd);
      last_rd = exp_rd;
    end else begin
      chk(host_rdata == last_rd, "R9", host_rdata, last_rd);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    host_addr = '0; host_size = '0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; dev_data_rdata = '0; dev_stat_rdata = '0;
    last_rd = '0;
    repeat (3) @(negedge clk);
    chk(dev_reset == 1'b1, "R11", {31'h0, dev_reset}, 32'h1);
    chk(host_rdata == 32'h0, "R9", host_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dev_reset == 1'b0, "R11", {31'h0, dev_reset}, 32'h0);

    // R1: upper address bits do not disturb the slot decode
    @(negedge clk);
    host_addr = 32'hFFFF_F03C; host_size = 2'b00; host_rd = 1'b1;
    #1;
    chk(dev_tf_rd && dev_tf_reg == 3'd3, "R1", {28'h0, dev_tf_rd, dev_tf_reg}, 32'hB);
    @(negedge clk);
    host_rd = 1'b0;
    chk(host_rdata == 32'h0000_00A3, "R1", host_rdata, 32'h0000_00A3);
    last_rd = 32'h0000_00A3;

    for (int idx = 0; idx < 256; idx++)
      for (int sz = 0; sz < 4; sz++)
        for (int op = 0; op < 2; op++)
          access(idx, sz, op == 0, op == 1, 20'(idx * 37 + sz * 5 + op));

    // R10: write and read together at the data port and at status
    access(0, 2, 1'b1, 1'b1, 20'h12345);
    access(8, 0, 1'b1, 1'b1, 20'h00001);
    access(22, 0, 1'b0, 1'b1, 20'hABCDE);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule